// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides whether a frame is kept, using only its 48-bit destination address. The address arrives one byte per cycle in wire order, with the first byte flagged. After the sixth byte the filter gives a verdict. A frame is kept when any enabled source of acceptance matches. The sources are two programmable station addresses, the all-ones broadcast address, and a 64-entry group hash table.

Software programs the filter through a small 32-bit register port. The port holds two station addresses, each split across a low and a high word, the two halves of the hash table, and a control word. The read path returns the value that was last written.

The hash index is six bits wide. The address is treated as a 48-bit vector whose bit n is bit (n mod 8) of byte (n div 8). The index is the XOR of the eight consecutive 6-bit slices of that vector. By default the hash path only applies to group addresses. A control bit extends it to individual addresses.

Top module: `rx_addr_filter`

## Requirements
- R1: Registers sit at byte offsets 0x00 (station 0 low), 0x04 (station 0 high), 0x08 (station 1 low), 0x0C (station 1 high), 0x10 (hash low), 0x14 (hash high) and 0x1C (control). A read at a mapped offset returns the last written 32-bit value. A write to any other offset changes nothing, and a read there returns zero. After reset every register reads zero.
- R2: A station address is built from its two registers as follows. Low register bits [7:0], [15:8], [23:16] and [31:24] form address bytes 0 to 3. High register bits [7:0] and [15:8] form bytes 4 and 5. High register bits [31:16] are not compared.
- R3: With control bit 0 set, a destination equal to station address 0 is accepted. With the bit clear, that address gives no acceptance.
- R4: With control bit 1 set, a destination equal to station address 1 is accepted. With the bit clear, that address gives no acceptance.
- R5: With control bit 3 set, the destination FF:FF:FF:FF:FF:FF is accepted.
- R6: The hash index is the XOR of the eight 6-bit slices of the destination, with bits taken from bit 0 of byte 0 upward. Indices 0 to 31 select that bit of the hash low register. Indices 32 to 63 select bit (index-32) of the hash high register. A set bit accepts the frame.
- R7: The hash path applies only when bit 0 of destination byte 0 is 1, unless control bit 2 is set, in which case it applies to every destination.
- R8: The verdict appears as a one-cycle valid pulse in the cycle after the clock edge that takes the sixth byte. Bytes may arrive with idle cycles between them. The accept output is 0 whenever the valid output is 0. A register write on the same edge as the sixth byte does not affect that verdict.
- R9: Bytes after the sixth are ignored until the next flagged first byte. A flagged first byte always restarts address assembly, even in the middle of an address.
- R10: When no enabled source matches, the valid pulse still appears with accept at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| rx_vld | input | 1 | Destination byte present |
| rx_first | input | 1 | Marks destination byte 0 |
| rx_byte | input | 8 | Destination byte in wire order |
| res_vld | output | 1 | One-cycle verdict pulse |
| res_accept | output | 1 | Frame accepted; valid only with res_vld |

## Verification
Read data is combinational, so each read-back is sampled a fraction of a cycle after the offset is driven, and register writes are complete one edge after the strobe. The verdict has exactly one register in its path. Each check therefore drives bytes on falling edges and samples res_vld and res_accept on the falling edge that follows the edge taking the sixth byte. The bench then confirms on the next falling edge that the pulse has dropped. Expected verdicts come from a bench model that rebuilds the hash bit by bit from the destination bytes and tracks the programmed register values itself.

// File: rtl/addrflt_pkg.sv
package addrflt_pkg;

  localparam int ADDR_BYTES = 6;
  localparam int ADDR_BITS  = 8 * ADDR_BYTES;
  localparam int HASH_BITS  = 6;
  localparam int TBL_SIZE   = 1 << HASH_BITS;

  localparam logic [4:0] OFS_STA0_LO = 5'h00;
  localparam logic [4:0] OFS_STA0_HI = 5'h04;
  localparam logic [4:0] OFS_STA1_LO = 5'h08;
  localparam logic [4:0] OFS_STA1_HI = 5'h0C;
  localparam logic [4:0] OFS_HASH_LO = 5'h10;
  localparam logic [4:0] OFS_HASH_HI = 5'h14;
  localparam logic [4:0] OFS_CTRL    = 5'h1C;

  // control word: bit3 broadcast, bit2 hash for all, bit1 station 1, bit0 station 0
  typedef struct packed {
    logic bcast_en;
    logic hash_all;
    logic sta1_en;
    logic sta0_en;
  } rx_ctrl_t;

  // XOR-fold the destination into a 6-bit table index
  function automatic logic [HASH_BITS-1:0] fold_hash(input logic [ADDR_BITS-1:0] a);
    logic [HASH_BITS-1:0] h;
    h = '0;
    for (int s = 0; s < ADDR_BITS / HASH_BITS; s++)
      h = h ^ a[s*HASH_BITS +: HASH_BITS];
    return h;
  endfunction

  // station address from its low/high register pair, byte 0 in bits [7:0]
  function automatic logic [ADDR_BITS-1:0] join_station(input logic [31:0] lo,
                                                        input logic [31:0] hi);
    return {hi[15:0], lo};
  endfunction

endpackage

// File: rtl/addrflt_regs.sv
module addrflt_regs
  import addrflt_pkg::*;
#(
  parameter int RAW = 5,
  parameter int RDW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [RAW-1:0]       addr,
  input  logic [RDW-1:0]       wdata,
  output logic [RDW-1:0]       rdata,
  output logic [ADDR_BITS-1:0] sta0,
  output logic [ADDR_BITS-1:0] sta1,
  output logic [TBL_SIZE-1:0]  table_bits,
  output rx_ctrl_t             ctrl
);

  logic [RDW-1:0] sta0_lo_q, sta0_hi_q, sta1_lo_q, sta1_hi_q;
  logic [RDW-1:0] hash_lo_q, hash_hi_q, ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta0_lo_q <= '0;
      sta0_hi_q <= '0;
      sta1_lo_q <= '0;
      sta1_hi_q <= '0;
      hash_lo_q <= '0;
      hash_hi_q <= '0;
      ctrl_q    <= '0;
    end else if (wr) begin
      case (addr)
        OFS_STA0_LO: sta0_lo_q <= wdata;
        OFS_STA0_HI: sta0_hi_q <= wdata;
        OFS_STA1_LO: sta1_lo_q <= wdata;
        OFS_STA1_HI: sta1_hi_q <= wdata;
        OFS_HASH_LO: hash_lo_q <= wdata;
        OFS_HASH_HI: hash_hi_q <= wdata;
        OFS_CTRL:    ctrl_q    <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_STA0_LO: rdata = sta0_lo_q;
      OFS_STA0_HI: rdata = sta0_hi_q;
      OFS_STA1_LO: rdata = sta1_lo_q;
      OFS_STA1_HI: rdata = sta1_hi_q;
      OFS_HASH_LO: rdata = hash_lo_q;
      OFS_HASH_HI: rdata = hash_hi_q;
      OFS_CTRL:    rdata = ctrl_q;
      default:     rdata = '0;
    endcase
  end

  assign sta0       = join_station(sta0_lo_q, sta0_hi_q);
  assign sta1       = join_station(sta1_lo_q, sta1_hi_q);
  assign table_bits = {hash_hi_q, hash_lo_q};
  assign ctrl       = rx_ctrl_t'(ctrl_q[3:0]);

  // R1: a write to the hash low word lands on the next edge
  a_r1_hash_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_HASH_LO) |=> (table_bits[31:0] == $past(wdata)));

  // R1: a write to the control word lands on the next edge
  a_r1_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_CTRL) |=> (ctrl == rx_ctrl_t'($past(wdata[3:0]))));

endmodule

// File: rtl/addrflt_capture.sv
module addrflt_capture
  import addrflt_pkg::*;
#(
  parameter int NB = ADDR_BYTES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            byte_vld,
  input  logic            byte_first,
  input  logic [7:0]      byte_data,
  output logic [8*NB-1:0] addr_full,
  output logic            fire
);

  localparam int CW = $clog2(NB + 1);

  logic [NB-2:0][7:0] hold_q;
  logic [CW-1:0]      cnt_q;
  logic [CW-1:0]      pos;
  logic               take;

  // cnt_q == NB means idle: waiting for a flagged first byte
  assign take = byte_vld && (byte_first || (cnt_q < CW'(NB)));
  assign pos  = byte_first ? '0 : cnt_q;
  assign fire = take && (pos == CW'(NB - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(NB);
    end else if (take) begin
      cnt_q <= pos + 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NB - 1; g++) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          hold_q[g] <= '0;
        else if (take && pos == CW'(g))
          hold_q[g] <= byte_data;
      end
      assign addr_full[8*g +: 8] = hold_q[g];
    end
  endgenerate

  // last byte bypasses storage so the verdict can be registered on its edge
  assign addr_full[8*(NB-1) +: 8] = byte_data;

  // R9: byte counter never leaves its range
  a_r9_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NB));

  // R9: after the final byte the capture is idle
  a_r9_idle_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == CW'(NB)));

endmodule

// File: rtl/addrflt_match.sv
module addrflt_match
  import addrflt_pkg::*;
(
  input  logic [ADDR_BITS-1:0] dst,
  input  logic [ADDR_BITS-1:0] sta0,
  input  logic [ADDR_BITS-1:0] sta1,
  input  logic [TBL_SIZE-1:0]  table_bits,
  input  rx_ctrl_t             ctrl,
  output logic                 hit_sta0,
  output logic                 hit_sta1,
  output logic                 hit_bcast,
  output logic                 hit_hash,
  output logic                 accept
);

  logic [HASH_BITS-1:0] idx;
  logic                 group_addr;

  assign idx        = fold_hash(dst);
  assign group_addr = dst[0];

  assign hit_sta0  = ctrl.sta0_en && (dst == sta0);
  assign hit_sta1  = ctrl.sta1_en && (dst == sta1);
  assign hit_bcast = ctrl.bcast_en && (&dst);
  assign hit_hash  = (group_addr || ctrl.hash_all) && table_bits[idx];
  assign accept    = hit_sta0 || hit_sta1 || hit_bcast || hit_hash;

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import addrflt_pkg::*;
#(
  parameter int RAW = 5,
  parameter int RDW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [RDW-1:0] reg_wdata,
  output logic [RDW-1:0] reg_rdata,
  input  logic           rx_vld,
  input  logic           rx_first,
  input  logic [7:0]     rx_byte,
  output logic           res_vld,
  output logic           res_accept
);

  logic [ADDR_BITS-1:0] sta0, sta1, dst;
  logic [TBL_SIZE-1:0]  table_bits;
  rx_ctrl_t             ctrl;
  logic                 fire;
  logic                 hit_sta0, hit_sta1, hit_bcast, hit_hash, accept;

  addrflt_regs #(.RAW(RAW), .RDW(RDW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .sta0       (sta0),
    .sta1       (sta1),
    .table_bits (table_bits),
    .ctrl       (ctrl)
  );

  addrflt_capture #(.NB(ADDR_BYTES)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (rx_vld),
    .byte_first (rx_first),
    .byte_data  (rx_byte),
    .addr_full  (dst),
    .fire       (fire)
  );

  addrflt_match u_match (
    .dst        (dst),
    .sta0       (sta0),
    .sta1       (sta1),
    .table_bits (table_bits),
    .ctrl       (ctrl),
    .hit_sta0   (hit_sta0),
    .hit_sta1   (hit_sta1),
    .hit_bcast  (hit_bcast),
    .hit_hash   (hit_hash),
    .accept     (accept)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld    <= 1'b0;
      res_accept <= 1'b0;
    end else begin
      res_vld    <= fire;
      res_accept <= fire && accept;
    end
  end

  // R8: the verdict is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);

  // R8: a verdict only follows an edge that took a byte
  a_r8_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(rx_vld));

  // R8: accept is quiet outside the pulse
  a_r8_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> !res_accept);

  // R5: a broadcast hit on the final byte yields acceptance
  a_r5_bcast_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hit_bcast) |=> res_accept);

endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_vld = 1'b0;
  logic        rx_first = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        res_vld, res_accept;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_vld(rx_vld),
    .rx_first(rx_first), .rx_byte(rx_byte), .res_vld(res_vld),
    .res_accept(res_accept)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // bench hash: walk every bit, bit n of the address goes to index bit n%6
  function automatic logic [5:0] ref_idx(input logic [7:0] b [6]);
    logic [5:0] h = '0;
    for (int n = 0; n < 48; n++)
      if (b[n / 8][n % 8]) h[n % 6] = ~h[n % 6];
    return h;
  endfunction

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // send six bytes; sample on the falling edge after the edge taking byte 5
  task automatic send_dst(input logic [7:0] b [6], output logic v, output logic acc);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rx_vld = 1'b1; rx_first = (k == 0); rx_byte = b[k];
    end
    @(negedge clk);
    rx_vld = 1'b0; rx_first = 1'b0;
    v = res_vld; acc = res_accept;
  endtask

  task automatic expect_verdict(input string req, input logic [7:0] b [6], input logic exp);
    logic v, a;
    send_dst(b, v, a);
    chk(req, {31'b0, v}, 32'd1);
    chk(req, {31'b0, a}, {31'b0, exp});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [4:0] ofs [7] = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h1C};
    chk("R8 reset vld", {31'b0, res_vld}, 32'd0);
    foreach (ofs[i]) begin
      rd_reg(ofs[i], d);
      chk("R1 reset value", d, 32'd0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    logic [4:0] ofs [7] = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h1C};
    foreach (ofs[i]) wr_reg(ofs[i], 32'hA5000000 + 32'(i * 17));
    wr_reg(5'h18, 32'hDEADBEEF);
    foreach (ofs[i]) begin
      rd_reg(ofs[i], d);
      chk("R1 readback", d, 32'hA5000000 + 32'(i * 17));
    end
    rd_reg(5'h18, d);
    chk("R1 unmapped read", d, 32'd0);
    foreach (ofs[i]) wr_reg(ofs[i], 32'd0);
  endtask

  task automatic t_station(input int which);
    logic [7:0] b [6] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    logic [4:0] lo = (which == 0) ? 5'h00 : 5'h08;
    logic [4:0] hi = (which == 0) ? 5'h04 : 5'h0C;
    string rq = (which == 0) ? "R3" : "R4";
    wr_reg(lo, 32'h33221102);
    wr_reg(hi, 32'hABCD5544);  // R2: upper half of high word not compared
    wr_reg(5'h1C, (which == 0) ? 32'h1 : 32'h2);
    expect_verdict({rq, " R2 match"}, b, 1'b1);
    b[5] = 8'h56;
    expect_verdict({rq, " R10 last byte differs"}, b, 1'b0);
    b[5] = 8'h55; b[0] = 8'h00;
    expect_verdict({rq, " R10 first byte differs"}, b, 1'b0);
    b[0] = 8'h02;
    wr_reg(5'h1C, (which == 0) ? 32'h2 : 32'h1);
    expect_verdict({rq, " disabled"}, b, 1'b0);
    wr_reg(5'h1C, 32'h0); wr_reg(lo, 32'h0); wr_reg(hi, 32'h0);
  endtask

  task automatic t_bcast();
    logic [7:0] b [6] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    wr_reg(5'h1C, 32'h8);
    expect_verdict("R5 broadcast on", b, 1'b1);
    wr_reg(5'h1C, 32'h0);
    expect_verdict("R5 broadcast off", b, 1'b0);
  endtask

  // find an address with a given byte0 whose index lands in the wanted half
  task automatic pick(input logic [7:0] b0, input bit upper, output logic [7:0] b [6],
                      output logic [5:0] idx);
    for (int v = 0; v < 256; v++) begin
      b = '{b0, 8'h5A, 8'h3C, 8'h00, 8'h7E, 8'(v)};
      idx = ref_idx(b);
      if (idx[5] == upper) break;
    end
  endtask

  task automatic t_hash(input bit upper);
    logic [7:0] b [6];
    logic [5:0] idx;
    logic [4:0] ofs;
    string rq;
    pick(8'h01, upper, b, idx);
    ofs = upper ? 5'h14 : 5'h10;
    rq = upper ? "R6 high table" : "R6 low table";
    wr_reg(ofs, 32'(1) << idx[4:0]);
    expect_verdict(rq, b, 1'b1);
    wr_reg(ofs, ~(32'(1) << idx[4:0]));
    wr_reg(upper ? 5'h10 : 5'h14, 32'hFFFFFFFF);
    expect_verdict({rq, " R10 other bits"}, b, 1'b0);
    wr_reg(5'h10, 32'h0); wr_reg(5'h14, 32'h0);
  endtask

  task automatic t_hash_unicast();
    logic [7:0] b [6];
    logic [5:0] idx;
    pick(8'h00, 1'b0, b, idx);
    wr_reg(5'h10, 32'(1) << idx[4:0]);
    wr_reg(5'h1C, 32'h0);
    expect_verdict("R7 unicast no hash", b, 1'b0);
    wr_reg(5'h1C, 32'h4);
    expect_verdict("R7 hash all", b, 1'b1);
    wr_reg(5'h1C, 32'h0); wr_reg(5'h10, 32'h0);
  endtask

  task automatic t_timing();
    logic [7:0] b [6] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    wr_reg(5'h1C, 32'h8);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rx_vld = 1'b1; rx_first = (k == 0); rx_byte = b[k];
      @(negedge clk);
      rx_vld = 1'b0; rx_first = 1'b0;
      if (k < 5) chk("R8 no early pulse", {31'b0, res_vld}, 32'd0);
      else begin
        chk("R8 pulse with gaps", {31'b0, res_vld}, 32'd1);
        chk("R8 accept with gaps", {31'b0, res_accept}, 32'd1);
      end
    end
    @(negedge clk);
    chk("R8 pulse drops", {31'b0, res_vld}, 32'd0);
    chk("R8 accept drops", {31'b0, res_accept}, 32'd0);
    // write on the same edge as byte 5 must not affect the verdict
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rx_vld = 1'b1; rx_first = (k == 0); rx_byte = b[k];
      if (k == 5) begin reg_wr = 1'b1; reg_addr = 5'h1C; reg_wdata = 32'h0; end
    end
    @(negedge clk);
    rx_vld = 1'b0; reg_wr = 1'b0;
    chk("R8 same-edge write vld", {31'b0, res_vld}, 32'd1);
    chk("R8 same-edge write acc", {31'b0, res_accept}, 32'd1);
  endtask

  task automatic t_extra();
    logic [7:0] b [6] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    logic v, a;
    int pulses = 0;
    wr_reg(5'h1C, 32'h8);
    send_dst(b, v, a);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rx_vld = 1'b1; rx_first = 1'b0; rx_byte = 8'hFF;
      #1 if (res_vld) pulses++;
    end
    @(negedge clk);
    rx_vld = 1'b0;
    if (res_vld) pulses++;
    chk("R9 trailing bytes ignored", 32'(pulses), 32'd0);
    // partial address then restart with a non-broadcast address
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rx_vld = 1'b1; rx_first = (k == 0); rx_byte = 8'hFF;
    end
    b = '{8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    expect_verdict("R9 restart on first", b, 1'b0);
    wr_reg(5'h1C, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_station(0);
    t_station(1);
    t_bcast();
    t_hash(1'b0);
    t_hash(1'b1);
    t_hash_unicast();
    t_timing();
    t_extra();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule